// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is a per-processor interval timer. A free-running prescaler divides the core clock by a power of two chosen through a divide register. Each prescaled tick steps a 32-bit down-counter that was loaded from an initial-count register. When the counter has run through its whole period, the block raises a one-cycle interrupt request together with the 8-bit vector held in its control entry. The request is suppressed when the entry's mask bit is set.

Software drives the block through a single 32-bit register port with a write strobe and a two-bit register address. Reads are combinational. The control entry selects between one-shot operation, where the counter stops at zero, and periodic operation, where the counter reloads after every expiry.

Top module: `tick_timer`

## Requirements
- R1: A write to the divide register (address 3) stores only bits 3, 1 and 0 of the write data. All other bits read back as zero.
- R2: The 3-bit divide code is {bit3, bit1, bit0}. One tick occurs every 2^((code+1) mod 8) clock cycles. Code 111 gives one tick per cycle, code 000 gives one tick every 2 cycles, and code 100 gives one tick every 32 cycles.
- R3: A write to the initial-count register (address 1) loads the current count with the written value and restarts the prescaler phase. With a divide of 2^s, the first decrement lands 2^s cycles after the write edge.
- R4: In one-shot mode (entry bit 17 clear), the count decrements once per tick. The single expiry occurs on the tick after the count reaches zero, that is (initial+1) ticks after the load. After that the count holds at zero. An initial count of zero never expires.
- R5: In periodic mode (entry bit 17 set), the count reloads the initial value on each expiry tick, so expiries repeat every initial+1 ticks. An initial count of zero gives no expiry.
- R6: When entry bit 16 (mask) is set, an expiry produces no pulse, but counting and reloading carry on unchanged.
- R7: `irq_pulse` is high for exactly one clock cycle, starting in the cycle after the clock edge at which the expiry tick occurs.
- R8: While `irq_pulse` is high, `irq_vector` equals entry bits 7:0 as they were at the expiry tick.
- R9: After reset, the entry reads 0x00010000 (masked), the initial count, current count and divide register read zero, and no pulse is given.
- R10: Writing the control entry (address 0) neither reloads nor stops the count. The new mode, mask and vector bits take effect from the next tick.
- R11: Address 2 reads the current count and ignores writes. Address 0 and address 1 read back their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 entry, 1 initial count, 2 current count, 3 divide |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request on an unmasked expiry |
| irq_vector | output | 8 | Vector that goes with `irq_pulse` |

## Verification
A wrong count, reload value or running state shows up at the port within one read of address 2. It also shifts the cycle of the next `irq_pulse`, which the bench observes one cycle after the expiry tick. A prescaler phase fault changes when the first decrement appears: 2^s cycles after an initial-count write, at most 128 cycles away. A fault in the mask or mode latching appears as a missing, extra or doubled pulse during the following period. A cycle-accurate bench model compares the pulse and the count every idle cycle, so any divergence is reported in the cycle it reaches the ports.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;

  localparam logic [1:0] ADDR_ENTRY = 2'd0;
  localparam logic [1:0] ADDR_INIT  = 2'd1;
  localparam logic [1:0] ADDR_CUR   = 2'd2;
  localparam logic [1:0] ADDR_DIV   = 2'd3;

  localparam int ENTRY_MASK_BIT     = 16;
  localparam int ENTRY_PERIODIC_BIT = 17;
  localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;
  localparam logic [3:0]  DIV_KEEP    = 4'hB;

  // divide code {b3,b1,b0} -> prescale shift, wrapping 7 to 0
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [SHIFT_W-1:0] code);
    return code + 3'd1;
  endfunction

  // low-bit mask whose all-ones state marks a tick
  function automatic logic [PRE_W-1:0] shift_to_mask(input logic [SHIFT_W-1:0] sh);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << sh;
    return PRE_W'(one_hot - (PRE_W+1)'(1));
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler
  import tick_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] tick_mask;

  assign tick_mask = shift_to_mask(shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  assign tick = !restart && ((phase_q & tick_mask) == tick_mask);
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] cur,
  output logic [31:0]      entry_q,
  output logic [CNT_W-1:0] init_q,
  output logic [3:0]       div_q,
  output logic             load,
  output logic [31:0]      rdata
);
  assign load = wr && (addr == ADDR_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= ENTRY_RESET;
      init_q  <= '0;
      div_q   <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_ENTRY: entry_q <= wdata;
        ADDR_INIT:  init_q  <= CNT_W'(wdata);
        ADDR_DIV:   div_q   <= wdata[3:0] & DIV_KEEP;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_ENTRY: rdata = entry_q;
      ADDR_INIT:  rdata = 32'(init_q);
      ADDR_CUR:   rdata = 32'(cur);
      default:    rdata = {28'd0, div_q};
    endcase
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic             masked,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] cur_q,
  output logic             run_q,
  output logic             expire,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  assign expire = tick && run_q && (cur_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      run_q      <= 1'b0;
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= 1'b0;
      if (load) begin
        cur_q <= load_val;
        run_q <= (load_val != '0);
      end else if (expire) begin
        irq_pulse  <= !masked;
        irq_vector <= vector;
        if (periodic) cur_q <= reload_val;
        else          run_q <= 1'b0;
      end else if (tick && run_q) begin
        cur_q <= cur_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  logic [31:0]        entry_q;
  logic [CNT_W-1:0]   init_q;
  logic [3:0]         div_q;
  logic               load;
  logic [SHIFT_W-1:0] shift;
  logic               tick;
  logic [CNT_W-1:0]   cur_q;
  logic               run_q;
  logic               expire;

  tt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cur(cur_q), .entry_q(entry_q), .init_q(init_q), .div_q(div_q),
    .load(load), .rdata(reg_rdata)
  );

  assign shift = div_to_shift({div_q[3], div_q[1:0]});

  tt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load), .shift(shift), .tick(tick)
  );

  tt_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(CNT_W'(reg_wdata)),
    .reload_val(init_q), .tick(tick),
    .periodic(entry_q[ENTRY_PERIODIC_BIT]), .masked(entry_q[ENTRY_MASK_BIT]),
    .vector(entry_q[VEC_W-1:0]), .cur_q(cur_q), .run_q(run_q), .expire(expire),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             irq_pulse,
  input logic             tick,
  input logic             load,
  input logic             expire,
  input logic             running,
  input logic             periodic,
  input logic             masked,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] init
);
  p_div_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_DIV) |-> ((reg_rdata & 32'hFFFF_FFF4) == 32'd0));

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(CNT_W'(reg_wdata))));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && cur != '0) |=> (cur == $past(cur) - 1'b1));

  p_stopped_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> ($stable(cur) && !irq_pulse));

  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> !running);

  p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cur == $past(init)));

  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(expire) && !$past(masked)));

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_pulse(irq_pulse), .tick(tick), .load(load),
  .expire(expire), .running(run_q), .periodic(entry_q[17]),
  .masked(entry_q[16]), .cur(cur_q), .init(init_q)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  // cycles per tick, from the requirement R2 encoding
  function automatic int ref_div(input logic [31:0] d);
    int code;
    code = (d[3] ? 4 : 0) + (d[1] ? 2 : 0) + (d[0] ? 1 : 0);
    if (code == 7) return 1;
    return 1 << (code + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  logic [31:0] m_entry, m_init, m_cur, m_div, m_cyc;
  logic        m_run, m_pulse;
  logic [7:0]  m_vec;
  logic        m_tk;
  assign m_tk = ((m_cyc + 1) % ref_div(m_div)) == 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_entry <= 32'h0001_0000; m_init <= 0; m_cur <= 0; m_div <= 0;
      m_cyc <= 0; m_run <= 0; m_pulse <= 0; m_vec <= 0;
    end else begin
      m_pulse <= 1'b0;
      if (reg_wr && reg_addr == 2'd0) m_entry <= reg_wdata;
      if (reg_wr && reg_addr == 2'd3) m_div <= reg_wdata & 32'hB;
      if (reg_wr && reg_addr == 2'd1) begin
        m_init <= reg_wdata; m_cur <= reg_wdata; m_run <= (reg_wdata != 0); m_cyc <= 0;
      end else begin
        m_cyc <= m_cyc + 1;
        if (m_tk && m_run) begin
          if (m_cur == 0) begin
            m_pulse <= !m_entry[16];
            m_vec   <= m_entry[7:0];
            if (m_entry[17]) m_cur <= m_init;
            else m_run <= 1'b0;
          end else m_cur <= m_cur - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (cmp_on && !done) begin
      check("R7 pulse vs model", {31'd0, irq_pulse}, {31'd0, m_pulse});
      if (irq_pulse && m_pulse) check("R8 vector vs model", {24'd0, irq_vector}, {24'd0, m_vec});
      if (reg_addr == 2'd2 && !reg_wr) check("R4 count vs model", reg_rdata, m_cur);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_addr = 2'd2;
  endtask

  // negedges after the current one until a pulse; 0 if none within lim
  task automatic wait_pulse(input int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      #1;
      if (irq_pulse) begin k = i; return; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int k, k2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R9 no pulse after reset", {31'd0, irq_pulse}, 32'd0);
    rd(2'd0, v); check("R9 entry reset", v, 32'h0001_0000);
    rd(2'd1, v); check("R9 initial reset", v, 32'd0);
    rd(2'd2, v); check("R9 current reset", v, 32'd0);
    rd(2'd3, v); check("R9 divide reset", v, 32'd0);
    cmp_on = 1'b1;

    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R1 divide keeps 3,1,0", v, 32'hB);
    wr(2'd3, 32'hFFFF_FFF4); rd(2'd3, v); check("R1 divide drops others", v, 32'h0);
    wr(2'd2, 32'h55); rd(2'd2, v); check("R11 current ignores write", v, 32'd0);

    // one-shot, divide 1, init 3: pulse at 4th cycle
    wr(2'd0, 32'h0000_0042); rd(2'd0, v); check("R11 entry readback", v, 32'h42);
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd3);
    wait_pulse(40, k); check("R4 one-shot expiry cycle", k, 4);
    check("R8 vector", {24'd0, irq_vector}, 32'h42);
    @(negedge clk); #1 check("R7 one-cycle pulse", {31'd0, irq_pulse}, 32'd0);
    wait_pulse(40, k); check("R4 single expiry", k, 0);
    rd(2'd2, v); check("R4 holds zero", v, 32'd0);
    rd(2'd1, v); check("R11 initial readback", v, 32'd3);

    // divide code 000 -> 2 cycles per tick
    wr(2'd3, 32'h0); wr(2'd1, 32'd3);
    wait_pulse(60, k); check("R2 code 000 divide by 2", k, 8);
    // divide code 100 -> 32 cycles per tick
    wr(2'd3, 32'h8); wr(2'd1, 32'd1);
    wait_pulse(200, k); check("R2 code 100 divide by 32", k, 64);
    // R3: first decrement 32 cycles after load
    wr(2'd1, 32'd9);
    repeat (30) @(negedge clk);
    #1 check("R3 not yet decremented", reg_rdata, 32'd9);
    repeat (2) @(negedge clk);
    #1 check("R3 first decrement", reg_rdata, 32'd8);

    // periodic, divide 1, init 2: period 3
    wr(2'd3, 32'hB); wr(2'd0, 32'h0002_0017); wr(2'd1, 32'd2);
    wait_pulse(40, k); check("R5 periodic first", k, 3);
    wait_pulse(40, k2); check("R5 periodic period", k2, 3);
    wait_pulse(40, k2); check("R5 periodic repeats", k2, 3);
    check("R8 periodic vector", {24'd0, irq_vector}, 32'h17);
    wr(2'd1, 32'd0);
    wait_pulse(60, k); check("R5 zero initial no expiry", k, 0);
    wr(2'd0, 32'h0000_0017); wr(2'd1, 32'd0);
    wait_pulse(30, k); check("R4 zero initial no expiry", k, 0);

    // masked periodic keeps counting
    wr(2'd0, 32'h0003_0021); wr(2'd1, 32'd5);
    wait_pulse(30, k); check("R6 masked no pulse", k, 0);
    rd(2'd2, v); rd(2'd2, v2); check("R6 count moves while masked", {31'd0, v != v2}, 32'd1);

    // entry write does not disturb count (divide 128)
    wr(2'd3, 32'hA); wr(2'd1, 32'd100);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h0002_0033);
    rd(2'd2, v); check("R10 entry write keeps count", v, 32'd100);
    wait_pulse(300, k); rd(2'd2, v); check("R10 count continues", v, 32'd98);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: wr(2'd3, $urandom);
        1: wr(2'd0, {14'd0, 1'b1 & $urandom, 1'b1 & $urandom, 8'd0, 8'($urandom)});
        2, 3: wr(2'd1, $urandom % 24);
        4: wr(2'd3, 32'hB);
        default: repeat ($urandom % 40) @(negedge clk);
      endcase
    end
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule